// File: doc/BRIEF.md
# UART transmitter with break generation

This block is the send half of an asynchronous serial port. A host places a character in a one-entry holding register with a write strobe. The block moves it into a shift register and drives it onto a serial line, one bit for each pulse of an externally supplied baud-tick strobe. Level control inputs select the frame width (8 or 9 data bits) and whether break characters are stretched. They also enable the transmitter and request break characters. Two status flags report that the holding register is free and that the line has fallen quiet. Each flag is masked by its own enable to form an interrupt request.

Besides data frames the shifter sends two special characters. A break is an all-zero character whose length depends on the frame width and the long-break select. A break request is latched on its rising edge, so a short pulse yields one whole break. A held request yields whole breaks back to back. An idle preamble is an all-ones character of frame length. It is queued each time the transmitter enable goes from low to high. When several characters wait at once, they go out in a fixed order: preamble, then break, then data.

Top module: `uart_brk_tx`

## Requirements
- R1: A data frame is a 0 start bit, then the data bits least significant first, then a 1 stop bit. There are 8 data bits when `wide_frame` is 0, and in that mode `data_in[8]` has no effect. There are 9 data bits when `wide_frame` is 1. Each bit is held on `txd` for exactly one baud-tick interval.
- R2: A low-to-high change of `tx_en` queues an idle preamble. The preamble is 10 ones (`wide_frame`=0) or 11 ones (`wide_frame`=1) and goes out before any queued data.
- R3: A break is a run of 0s on `txd`. With `long_brk`=0 it is 10 bits (`wide_frame`=0) or 11 bits (`wide_frame`=1). With `long_brk`=1 it is 13 or 14 bits.
- R4: A rising edge on `brk_cmd` produces exactly one complete break, even if `brk_cmd` falls again before that break has started or ended.
- R5: While `brk_cmd` stays high, whole breaks follow one another with no gap. Releasing it never shortens the break in progress.
- R6: When a preamble, a break and data are all waiting, they are sent in that order.
- R7: With `tx_en` low, no new character starts and `txd` rests at 1 once the current character has finished. A character already under way when `tx_en` falls is completed.
- R8: `buf_empty` is 1 after reset. It goes to 0 in the cycle after a `data_wr` pulse. It returns to 1 on the baud tick that moves the held character into the shifter.
- R9: `tx_done` is 1 after reset and whenever the shifter is idle with no data, break or preamble waiting. It goes to 0 in the cycle after a `data_wr` pulse.
- R10: `empty_irq` equals `buf_empty` AND `empty_ie`. `done_irq` equals `tx_done` AND `done_ie`.
- R11: A character that is waiting when the current one ends starts on the same baud tick that ends the current one, so there are no idle bits between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle strobe per bit time |
| tx_en | input | 1 | Transmitter enable; a rising edge queues a preamble |
| brk_cmd | input | 1 | Break request, level; its rising edge is latched |
| long_brk | input | 1 | Adds three bits to each break |
| wide_frame | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| data_wr | input | 1 | Write strobe for the holding register |
| data_in | input | 9 | Character to send |
| empty_ie | input | 1 | Mask for the empty interrupt |
| done_ie | input | 1 | Mask for the done interrupt |
| txd | output | 1 | Serial line, idles high |
| buf_empty | output | 1 | Holding register free |
| tx_done | output | 1 | Line quiet, nothing waiting |
| empty_irq | output | 1 | Masked empty request |
| done_irq | output | 1 | Masked done request |

## Verification
A wrong bit counter or a wrong shift register shows up on `txd` within one character time. It appears as a frame, break or preamble that is one or more ticks too long or too short, or as the next character starting at the wrong tick. A lost or doubled break latch, or a wrong preamble latch, changes the serial stream on the very next character boundary. A wrong holding-register flag shows up on `buf_empty` and `tx_done` within one clock of a write, or at the tick that loads the shifter. For that reason the line is recorded on every tick and compared bit for bit against a stream built from the requirements, and the flags are sampled around each write and load.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  // Kind of character the shifter is asked to load next
  typedef enum logic [1:0] {
    JOB_NONE = 2'd0,
    JOB_PRE  = 2'd1,
    JOB_BRK  = 2'd2,
    JOB_DATA = 2'd3
  } job_e;
endpackage

// File: rtl/ubt_jobsel.sv
module ubt_jobsel
  import ubt_pkg::*;
#(
  parameter int WIDE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              brk_cmd,
  input  logic              data_wr,
  input  logic [WIDE_W-1:0] data_in,
  input  logic              take,
  output job_e              job,
  output logic [WIDE_W-1:0] data_q,
  output logic              full
);

  logic en_q, brk_q, pre_pend, brk_pend;
  logic pre_pend_n, brk_pend_n, full_n;

  // Fixed order: preamble, break (latched or held), data
  always_comb begin
    if (pre_pend)                 job = JOB_PRE;
    else if (brk_pend || brk_cmd) job = JOB_BRK;
    else if (full)                job = JOB_DATA;
    else                          job = JOB_NONE;
  end

  always_comb begin
    pre_pend_n = pre_pend;
    if (take && job == JOB_PRE) pre_pend_n = 1'b0;
    if (tx_en && !en_q)         pre_pend_n = 1'b1;

    brk_pend_n = brk_pend;
    if (brk_cmd && !brk_q)      brk_pend_n = 1'b1;
    if (take && job == JOB_BRK) brk_pend_n = 1'b0;

    full_n = full;
    if (take && job == JOB_DATA) full_n = 1'b0;
    if (data_wr)                 full_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      brk_q    <= 1'b0;
      pre_pend <= 1'b0;
      brk_pend <= 1'b0;
      full     <= 1'b0;
    end else begin
      en_q     <= tx_en;
      brk_q    <= brk_cmd;
      pre_pend <= pre_pend_n;
      brk_pend <= brk_pend_n;
      full     <= full_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_wr) data_q <= data_in;
  end

  AST_BRK_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_cmd) |=> (brk_pend || $past(take && job == JOB_BRK))); // R4

endmodule

// File: rtl/ubt_shifter.sv
module ubt_shifter
  import ubt_pkg::*;
#(
  parameter int NARROW_W   = 8,
  parameter int WIDE_W     = 9,
  parameter int LONG_EXTRA = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_en,
  input  job_e              job,
  input  logic [WIDE_W-1:0] data,
  input  logic              wide_frame,
  input  logic              long_brk,
  output logic              take,
  output logic              busy,
  output logic              txd
);

  localparam int SR_W  = WIDE_W + 2 + LONG_EXTRA;
  localparam int CNT_W = $clog2(SR_W + 1);
  localparam logic [CNT_W-1:0] LEN_N = CNT_W'(NARROW_W + 2);
  localparam logic [CNT_W-1:0] LEN_W = CNT_W'(WIDE_W + 2);
  localparam logic [CNT_W-1:0] EXTRA = CNT_W'(LONG_EXTRA);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [SR_W-1:0]  sr, sr_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [CNT_W-1:0] flen;
  logic             busy_n;

  assign flen = wide_frame ? LEN_W : LEN_N;
  // A new character loads on an idle tick or on the tick ending the current one
  assign take = baud_tick && tx_en && (job != JOB_NONE) && (!busy || cnt == ONE);
  assign txd  = busy ? sr[0] : 1'b1;

  always_comb begin
    sr_n   = sr;
    cnt_n  = cnt;
    busy_n = busy;
    if (baud_tick && busy) begin
      if (cnt == ONE) begin
        busy_n = 1'b0;
      end else begin
        sr_n  = {1'b1, sr[SR_W-1:1]};
        cnt_n = cnt - ONE;
      end
    end
    if (take) begin
      busy_n = 1'b1;
      case (job)
        JOB_PRE: begin
          sr_n  = '1;
          cnt_n = flen;
        end
        JOB_BRK: begin
          sr_n  = '0;
          cnt_n = long_brk ? flen + EXTRA : flen;
        end
        default: begin
          sr_n    = '1;
          sr_n[0] = 1'b0;
          if (wide_frame) sr_n[WIDE_W:1]   = data;
          else            sr_n[NARROW_W:1] = data[NARROW_W-1:0];
          cnt_n   = flen;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '1;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (baud_tick) begin
      sr   <= sr_n;
      cnt  <= cnt_n;
      busy <= busy_n;
    end
  end

  AST_TXD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(txd)); // R1

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt != '0 && cnt <= CNT_W'(SR_W))); // R3

endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx #(
  parameter int NARROW_W   = 8,
  parameter int WIDE_W     = 9,
  parameter int LONG_EXTRA = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_en,
  input  logic              brk_cmd,
  input  logic              long_brk,
  input  logic              wide_frame,
  input  logic              data_wr,
  input  logic [WIDE_W-1:0] data_in,
  input  logic              empty_ie,
  input  logic              done_ie,
  output logic              txd,
  output logic              buf_empty,
  output logic              tx_done,
  output logic              empty_irq,
  output logic              done_irq
);

  ubt_pkg::job_e     job;
  logic              take, busy, full;
  logic [WIDE_W-1:0] data_q;

  ubt_jobsel #(.WIDE_W(WIDE_W)) u_jobsel (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_en   (tx_en),
    .brk_cmd (brk_cmd),
    .data_wr (data_wr),
    .data_in (data_in),
    .take    (take),
    .job     (job),
    .data_q  (data_q),
    .full    (full)
  );

  ubt_shifter #(
    .NARROW_W   (NARROW_W),
    .WIDE_W     (WIDE_W),
    .LONG_EXTRA (LONG_EXTRA)
  ) u_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .tx_en      (tx_en),
    .job        (job),
    .data       (data_q),
    .wide_frame (wide_frame),
    .long_brk   (long_brk),
    .take       (take),
    .busy       (busy),
    .txd        (txd)
  );

  assign buf_empty = !full;
  assign tx_done   = !busy && (job == ubt_pkg::JOB_NONE);
  assign empty_irq = buf_empty && empty_ie;
  assign done_irq  = tx_done && done_ie;

  AST_WR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !buf_empty); // R8

  AST_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !tx_done); // R9

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !busy) |=> txd); // R7

endmodule

// File: tb/uart_brk_tx_tb.sv
module uart_brk_tx_tb;
  localparam int CLK_P      = 10;
  localparam int TICK_DIV   = 4;
  localparam int NARROW_W   = 8;
  localparam int WIDE_W     = 9;
  localparam int LONG_EXTRA = 3;
  localparam int RB         = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, brk_cmd = 1'b0, long_brk = 1'b0, wide_frame = 1'b0;
  logic data_wr = 1'b0, empty_ie = 1'b0, done_ie = 1'b0;
  logic [WIDE_W-1:0] data_in = '0;
  logic txd, buf_empty, tx_done, empty_irq, done_irq;
  logic baud_tick;
  logic [1:0] div;
  logic tick_hit = 1'b0;

  int checks = 0, errors = 0, cyc = 0, tick_no = 0, base = 0;
  bit done_flag = 1'b0;
  logic rec [0:RB-1];
  bit expq[$];

  uart_brk_tx #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W), .LONG_EXTRA(LONG_EXTRA)) u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en), .brk_cmd(brk_cmd),
    .long_brk(long_brk), .wide_frame(wide_frame), .data_wr(data_wr), .data_in(data_in),
    .empty_ie(empty_ie), .done_ie(done_ie), .txd(txd), .buf_empty(buf_empty),
    .tx_done(tx_done), .empty_irq(empty_irq), .done_irq(done_irq));

  always #(CLK_P/2) clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div <= '0;
    else        div <= div + 2'd1;
  end
  assign baud_tick = rst_n && (div == 2'(TICK_DIV - 1));

  always @(posedge clk) tick_hit <= baud_tick;

  always @(negedge clk) begin
    if (tick_hit) begin
      rec[tick_no % RB] = txd;
      tick_no++;
    end
  end

  function automatic int flen(bit f9);
    return f9 ? WIDE_W + 2 : NARROW_W + 2;
  endfunction

  function automatic int blen(bit f9, bit lg);
    return flen(f9) + (lg ? LONG_EXTRA : 0);
  endfunction

  task automatic finish_run();
    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 40000 && !done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected end before 40000", cyc);
      finish_run();
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic push_bits(int n, bit v);
    for (int i = 0; i < n; i++) expq.push_back(v);
  endtask

  task automatic push_data(logic [WIDE_W-1:0] d, bit f9);
    expq.push_back(1'b0);
    for (int i = 0; i < (f9 ? WIDE_W : NARROW_W); i++) expq.push_back(d[i]);
    expq.push_back(1'b1);
  endtask

  task automatic sync();
    @(negedge clk);
    while (!tick_hit) @(negedge clk);
    #1;
    base = tick_no;
  endtask

  task automatic wait_ticks(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      while (!tick_hit) @(negedge clk);
    end
    #1;
  endtask

  task automatic pulse_wr(logic [WIDE_W-1:0] d);
    data_in = d;
    data_wr = 1'b1;
    @(posedge clk);
    #1;
    data_wr = 1'b0;
  endtask

  task automatic cmp_stream(string req, string what);
    int bad = -1;
    checks++;
    if (tick_no - base < expq.size()) bad = tick_no - base;
    else
      for (int i = 0; i < expq.size(); i++)
        if (bad < 0 && rec[(base + i) % RB] !== expq[i]) bad = i;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s %s: bit %0d actual %b expected %b", req, what, bad,
               (bad < tick_no - base) ? rec[(base + bad) % RB] : 1'bx,
               (bad < expq.size()) ? expq[bad] : 1'b0);
    end
    expq.delete();
  endtask

  initial begin
    logic [WIDE_W-1:0] d, d2;
    bit f9, lg;
    int len;
    void'($urandom(32'h5EED));

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk("R7", "txd after reset", txd, 1'b1);
    chk("R8", "buf_empty after reset", buf_empty, 1'b1);
    chk("R9", "tx_done after reset", tx_done, 1'b1);
    chk("R10", "empty_irq masked", empty_irq, 1'b0);
    chk("R10", "done_irq masked", done_irq, 1'b0);
    empty_ie = 1'b1; done_ie = 1'b1; #1;
    chk("R10", "empty_irq enabled", empty_irq, 1'b1);
    chk("R10", "done_irq enabled", done_irq, 1'b1);

    // R1 R2: enable then one frame, preamble first, random data and width
    for (int it = 0; it < 6; it++) begin
      f9 = (it < 2) ? bit'(it) : bit'($urandom % 2);
      wide_frame = f9;
      sync();
      tx_en = 1'b1;
      d = WIDE_W'($urandom);
      pulse_wr(d);
      @(negedge clk);
      chk("R8", "buf_empty after write", buf_empty, 1'b0);
      chk("R9", "tx_done after write", tx_done, 1'b0);
      empty_ie = 1'($urandom); done_ie = 1'($urandom); #1;
      chk("R10", "empty_irq with flag low", empty_irq, 1'b0);
      chk("R10", "done_irq with flag low", done_irq, 1'b0);
      push_bits(flen(f9), 1'b1);
      push_data(d, f9);
      push_bits(2, 1'b1);
      wait_ticks(expq.size());
      cmp_stream("R1 R2", "preamble then frame");
      chk("R8", "buf_empty after send", buf_empty, 1'b1);
      chk("R9", "tx_done after send", tx_done, 1'b1);
      chk("R10", "empty_irq follows mask", empty_irq, empty_ie);
      chk("R10", "done_irq follows mask", done_irq, done_ie);
      tx_en = 1'b0;
    end

    // R11: back-to-back frames with the enable held high
    sync();
    tx_en = 1'b1;
    wait_ticks(flen(1'b1) + 2);
    for (int it = 0; it < 4; it++) begin
      f9 = bit'($urandom % 2);
      wide_frame = f9;
      sync();
      d = WIDE_W'($urandom);
      d2 = WIDE_W'($urandom);
      pulse_wr(d);
      wait_ticks(1);
      chk("R8", "buf_empty after load", buf_empty, 1'b1);
      pulse_wr(d2);
      push_data(d, f9);
      push_data(d2, f9);
      push_bits(2, 1'b1);
      wait_ticks(expq.size() - 1);
      cmp_stream("R11", "two frames without gap");
    end

    // R3 R4: one short pulse gives one whole break, all four lengths
    for (int it = 0; it < 4; it++) begin
      f9 = bit'(it % 2);
      lg = bit'(it / 2);
      wide_frame = f9;
      long_brk = lg;
      sync();
      brk_cmd = 1'b1;
      @(posedge clk);
      #1;
      brk_cmd = 1'b0;
      push_bits(blen(f9, lg), 1'b0);
      push_bits(3, 1'b1);
      wait_ticks(expq.size());
      cmp_stream("R3 R4", "single break length");
      chk("R9", "tx_done after break", tx_done, 1'b1);
    end

    // R5: held request, released inside the third break
    f9 = bit'($urandom % 2);
    lg = bit'($urandom % 2);
    wide_frame = f9;
    long_brk = lg;
    len = blen(f9, lg);
    sync();
    brk_cmd = 1'b1;
    wait_ticks(2 * len + 2);
    chk("R9", "tx_done while breaking", tx_done, 1'b0);
    brk_cmd = 1'b0;
    push_bits(3 * len, 1'b0);
    push_bits(3, 1'b1);
    wait_ticks(len + 1);
    cmp_stream("R5", "held break not truncated");

    // R6: preamble, break and data all waiting at once
    tx_en = 1'b0;
    wide_frame = 1'b0;
    lg = bit'($urandom % 2);
    long_brk = lg;
    sync();
    tx_en = 1'b1;
    brk_cmd = 1'b1;
    d = WIDE_W'($urandom);
    pulse_wr(d);
    brk_cmd = 1'b0;
    push_bits(flen(1'b0), 1'b1);
    push_bits(blen(1'b0, lg), 1'b0);
    push_data(d, 1'b0);
    push_bits(2, 1'b1);
    wait_ticks(expq.size());
    cmp_stream("R6", "preamble, break, data order");

    // R7: disable mid-frame, frame completes, later data waits
    sync();
    d = WIDE_W'($urandom);
    d2 = WIDE_W'($urandom);
    pulse_wr(d);
    wait_ticks(3);
    tx_en = 1'b0;
    pulse_wr(d2);
    push_data(d, 1'b0);
    push_bits(12, 1'b1);
    wait_ticks(expq.size() - 3);
    cmp_stream("R7", "frame finished then line high");
    chk("R7", "buf_empty while disabled", buf_empty, 1'b0);
    chk("R9", "tx_done while data waits", tx_done, 1'b0);
    sync();
    tx_en = 1'b1;
    push_bits(flen(1'b0), 1'b1);
    push_data(d2, 1'b0);
    push_bits(2, 1'b1);
    wait_ticks(expq.size());
    cmp_stream("R2 R7", "re-enable sends preamble then held data");
    chk("R9", "tx_done at end", tx_done, 1'b1);

    finish_run();
  end
endmodule